// File: doc/BRIEF.md
# Banked Memory Mapper with Common Areas

This block sits between a processor with a 16-bit, 64KB address space and a larger physical memory built from 64KB banks. Each processor address is extended into a physical address by adding a bank number on top of it. The bank number comes from a bank-select register that software writes through a small, memory-mapped configuration write port.

Two fixed slices of the processor space ignore the selected bank and always map to bank 0. One slice is at the bottom of the space and one is at the top, and each is 1KB by default. These slices keep the zero page, the stack and the system-call entry code reachable from code running in any other bank. A slice can end partway through a page, and the rest of that page then maps to the selected bank.

The mapping is purely combinational from the address and the register. It has no input for privilege mode, so every mode gets the same translation. A bank-select width of 2 gives 256KB of physical memory, and a width of 3 gives 512KB.

Top module: `bank_mapper`

## Requirements
- R1: After reset the bank-select register holds 0, so every address maps into bank 0 until the first write.
- R2: Outside both common windows, the upper BANK_W bits of `phys_addr` equal the bank-select register.
- R3: Any `cpu_addr` below LOW_WIN_BYTES (0x0000 to 0x03FF by default) gives 0 in the upper BANK_W bits of `phys_addr`.
- R4: Any `cpu_addr` at or above 65536 minus HIGH_WIN_BYTES (0xFC00 to 0xFFFF by default) gives 0 in the upper BANK_W bits of `phys_addr`.
- R5: The window edges are exact. 0x03FF and 0xFC00 map to bank 0, while 0x0400 and 0xFBFF map to the selected bank.
- R6: A write with `cfg_wr_en` high and `cfg_wr_addr` equal to BANK_REG_ADDR (default 0) loads `cfg_wr_data` at the rising clock edge. Translations before that edge use the old bank, and translations after it use the new bank.
- R7: A write whose `cfg_wr_addr` differs from BANK_REG_ADDR leaves the bank-select register unchanged.
- R8: The low 16 bits of `phys_addr` always equal `cpu_addr`.
- R9: `phys_in_common` is 1 exactly when `cpu_addr` lies in either common window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | CFG_AW | Configuration register address |
| cfg_wr_data | input | BANK_W | Bank number to write |
| cpu_addr | input | 16 | Processor address |
| phys_addr | output | BANK_W+16 | Physical address {bank, cpu_addr} |
| phys_in_common | output | 1 | Address falls in a common window |

## Verification
A corrupted bank-select register appears on the upper bits of `phys_addr` for any address outside the windows. The error is visible in the same cycle the register changes, because the path is combinational. A faulty window compare shows up only at addresses near the window edges, so those edge addresses are probed with a nonzero bank selected. A wrong address decode on the write port appears one clock after the write, as a bank change that should not have happened or a change that is missing.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
   localparam int unsigned CPU_AW     = 16;
   localparam int unsigned CPU_SPACE  = 1 << CPU_AW;
   localparam int unsigned MAX_BANK_W = 3;

   // physical capacity in bytes for a given bank-select width
   function automatic int unsigned phys_bytes(input int unsigned bank_w);
      return CPU_SPACE << bank_w;
   endfunction
endpackage

// File: rtl/bank_sel_reg.sv
module bank_sel_reg #(
   parameter int unsigned BANK_W        = 2,
   parameter int unsigned CFG_AW        = 4,
   parameter int unsigned BANK_REG_ADDR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CFG_AW-1:0] wr_addr,
   input  logic [BANK_W-1:0] wr_data,
   output logic [BANK_W-1:0] bank_q
);
   localparam logic [CFG_AW-1:0] SEL_ADDR = CFG_AW'(BANK_REG_ADDR);

   logic hit;
   assign hit = wr_en && (wr_addr == SEL_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   bank_q <= '0;
      else if (hit) bank_q <= wr_data;
   end
endmodule

// File: rtl/common_window_decode.sv
module common_window_decode
   import bank_mapper_pkg::*;
#(
   parameter int unsigned LOW_WIN_BYTES  = 1024,
   parameter int unsigned HIGH_WIN_BYTES = 1024
) (
   input  logic [CPU_AW-1:0] addr,
   output logic              low_hit,
   output logic              high_hit
);
   localparam logic [CPU_AW:0] LOW_LIM  = (CPU_AW+1)'(LOW_WIN_BYTES);
   localparam logic [CPU_AW:0] HIGH_BASE = (CPU_AW+1)'(CPU_SPACE - HIGH_WIN_BYTES);

   logic [CPU_AW:0] addr_x;
   assign addr_x = {1'b0, addr};

   generate
      if (LOW_WIN_BYTES == 0) begin : g_no_low
         assign low_hit = 1'b0;
      end else begin : g_low
         assign low_hit = addr_x < LOW_LIM;
      end
      if (HIGH_WIN_BYTES == 0) begin : g_no_high
         assign high_hit = 1'b0;
      end else begin : g_high
         assign high_hit = addr_x >= HIGH_BASE;
      end
   endgenerate
endmodule

// File: rtl/phys_addr_form.sv
module phys_addr_form
   import bank_mapper_pkg::*;
#(
   parameter int unsigned BANK_W = 2
) (
   input  logic [CPU_AW-1:0]        addr,
   input  logic [BANK_W-1:0]        bank_sel,
   input  logic                     force_zero,
   output logic [BANK_W+CPU_AW-1:0] paddr
);
   logic [BANK_W-1:0] bank_eff;

   always_comb begin
      bank_eff = force_zero ? '0 : bank_sel;
      paddr    = {bank_eff, addr};
   end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
   import bank_mapper_pkg::*;
#(
   parameter int unsigned BANK_W         = 2,
   parameter int unsigned CFG_AW         = 4,
   parameter int unsigned BANK_REG_ADDR  = 0,
   parameter int unsigned LOW_WIN_BYTES  = 1024,
   parameter int unsigned HIGH_WIN_BYTES = 1024
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_wr_en,
   input  logic [CFG_AW-1:0]        cfg_wr_addr,
   input  logic [BANK_W-1:0]        cfg_wr_data,
   input  logic [CPU_AW-1:0]        cpu_addr,
   output logic [BANK_W+CPU_AW-1:0] phys_addr,
   output logic                     phys_in_common
);
   initial begin
      if (BANK_W < 1 || BANK_W > MAX_BANK_W)
         $error("bank_mapper: BANK_W must be 1..%0d", MAX_BANK_W);
      if (LOW_WIN_BYTES + HIGH_WIN_BYTES > CPU_SPACE)
         $error("bank_mapper: common windows overlap");
      if (CFG_AW < 1 || BANK_REG_ADDR >= (1 << CFG_AW))
         $error("bank_mapper: BANK_REG_ADDR out of range");
   end

   logic [BANK_W-1:0] bank_q;
   logic              low_hit, high_hit;

   bank_sel_reg #(
      .BANK_W(BANK_W), .CFG_AW(CFG_AW), .BANK_REG_ADDR(BANK_REG_ADDR)
   ) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en),
      .wr_addr(cfg_wr_addr), .wr_data(cfg_wr_data), .bank_q(bank_q)
   );

   common_window_decode #(
      .LOW_WIN_BYTES(LOW_WIN_BYTES), .HIGH_WIN_BYTES(HIGH_WIN_BYTES)
   ) u_win (
      .addr(cpu_addr), .low_hit(low_hit), .high_hit(high_hit)
   );

   phys_addr_form #(.BANK_W(BANK_W)) u_form (
      .addr(cpu_addr), .bank_sel(bank_q),
      .force_zero(low_hit | high_hit), .paddr(phys_addr)
   );

   assign phys_in_common = low_hit | high_hit;
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk
   import bank_mapper_pkg::*;
#(
   parameter int unsigned BANK_W         = 2,
   parameter int unsigned CFG_AW         = 4,
   parameter int unsigned BANK_REG_ADDR  = 0,
   parameter int unsigned LOW_WIN_BYTES  = 1024,
   parameter int unsigned HIGH_WIN_BYTES = 1024
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     cfg_wr_en,
   input logic [CFG_AW-1:0]        cfg_wr_addr,
   input logic [BANK_W-1:0]        cfg_wr_data,
   input logic [CPU_AW-1:0]        cpu_addr,
   input logic [BANK_W+CPU_AW-1:0] phys_addr,
   input logic                     phys_in_common
);
   localparam int unsigned TOP = BANK_W + CPU_AW - 1;

   logic in_low, in_high, sel_wr;
   assign in_low  = 32'(cpu_addr) < LOW_WIN_BYTES;
   assign in_high = 32'(cpu_addr) >= (CPU_SPACE - HIGH_WIN_BYTES);
   assign sel_wr  = cfg_wr_en && (32'(cfg_wr_addr) == BANK_REG_ADDR);

   p_reset_bank0_r1: assert property (@(posedge clk)
      !rst_n |=> phys_addr[TOP:CPU_AW] == '0);

   p_low_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_low |-> phys_addr[TOP:CPU_AW] == '0);

   p_high_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_high |-> phys_addr[TOP:CPU_AW] == '0);

   p_offset_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      phys_addr[CPU_AW-1:0] == cpu_addr);

   p_common_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      phys_in_common == (in_low || in_high));

   p_write_applies_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sel_wr) && !(in_low || in_high))
      |-> phys_addr[TOP:CPU_AW] == $past(cfg_wr_data));

   // R7 and R2: without a matching write, the bank seen outside the windows holds
   p_bank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(sel_wr) && !(in_low || in_high) && $past(!phys_in_common))
      |-> phys_addr[TOP:CPU_AW] == $past(phys_addr[TOP:CPU_AW]));
endmodule

bind bank_mapper bank_mapper_chk #(
   .BANK_W(BANK_W), .CFG_AW(CFG_AW), .BANK_REG_ADDR(BANK_REG_ADDR),
   .LOW_WIN_BYTES(LOW_WIN_BYTES), .HIGH_WIN_BYTES(HIGH_WIN_BYTES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
   .cfg_wr_data(cfg_wr_data), .cpu_addr(cpu_addr), .phys_addr(phys_addr),
   .phys_in_common(phys_in_common)
);

// File: tb/bank_mapper_tb_top.sv
module bank_mapper_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int BW = 2;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr_en = 1'b0;
   logic [AW-1:0] cfg_wr_addr = '0;
   logic [BW-1:0] cfg_wr_data = '0;
   logic [15:0]   cpu_addr = '0;
   logic [BW+15:0] phys_addr;
   logic          phys_in_common;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bank_mapper dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
      .cfg_wr_data(cfg_wr_data), .cpu_addr(cpu_addr), .phys_addr(phys_addr),
      .phys_in_common(phys_in_common)
   );

   task automatic check(input string req, input logic [BW+15:0] act, input logic [BW+15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic write_reg(input logic [AW-1:0] a, input logic [BW-1:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   task automatic probe(input string req, input logic [15:0] a, input logic [BW-1:0] bank);
      cpu_addr = a;
      #1;
      check(req, phys_addr, {bank, a});
   endtask

   task automatic t_reset;
      probe("R1", 16'h8000, 2'd0);
      probe("R1", 16'h2345, 2'd0);
   endtask

   task automatic t_mapping;
      write_reg(4'd0, 2'd1);
      probe("R2", 16'h1234, 2'd1);
      probe("R8", 16'hABCD, 2'd1);
      write_reg(4'd0, 2'd3);
      probe("R2", 16'h7FFF, 2'd3);
      probe("R8", 16'h0401, 2'd3);
   endtask

   task automatic t_windows;
      write_reg(4'd0, 2'd2);
      probe("R3", 16'h0000, 2'd0);
      probe("R3", 16'h0200, 2'd0);
      probe("R4", 16'hFFFF, 2'd0);
      probe("R4", 16'hFE10, 2'd0);
      cpu_addr = 16'h0100; #1;
      check("R9", BW'(0) + phys_in_common, 1);
      cpu_addr = 16'h8000; #1;
      check("R9", BW'(0) + phys_in_common, 0);
      cpu_addr = 16'hFC00; #1;
      check("R9", BW'(0) + phys_in_common, 1);
   endtask

   task automatic t_edges;
      write_reg(4'd0, 2'd3);
      probe("R5", 16'h03FF, 2'd0);
      probe("R5", 16'h0400, 2'd3);
      probe("R5", 16'hFBFF, 2'd3);
      probe("R5", 16'hFC00, 2'd0);
   endtask

   task automatic t_write_timing;
      write_reg(4'd0, 2'd1);
      @(negedge clk);
      cpu_addr = 16'h5000;
      cfg_wr_en = 1'b1; cfg_wr_addr = 4'd0; cfg_wr_data = 2'd2;
      #1;
      check("R6", phys_addr, {2'd1, 16'h5000});
      @(negedge clk);
      cfg_wr_en = 1'b0;
      #1;
      check("R6", phys_addr, {2'd2, 16'h5000});
   endtask

   task automatic t_ignored;
      write_reg(4'd0, 2'd2);
      write_reg(4'd5, 2'd1);
      probe("R7", 16'h6000, 2'd2);
      write_reg(4'd15, 2'd3);
      probe("R7", 16'h6000, 2'd2);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mapping();
      t_windows();
      t_edges();
      t_write_timing();
      t_ignored();
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule